// File: doc/BRIEF.md
# Dual-Byte Universal Bus Transceiver Datapath

This block carries data between an A side and a B side, each sixteen bits wide, split into two independent byte lanes. Every lane has two paths: one from A to B and one from B to A. Each path has three controls: a latch enable, a path clock and an output enable. One storage element on each path acts in three ways. With latch enable high it is transparent. With latch enable low and a steady path clock it holds its value. With latch enable low it loads new data on a rising edge of the path clock. The two lanes can run as two separate 8-bit transceivers, or they can be tied together to form one 16-bit transceiver.

The output enables have opposite polarity in the two directions. The A-to-B enable is active low and the B-to-A enable is active high. A single read/write line per lane can therefore pick the direction with no extra gates. The block has no true tri-state pins. Each path gives its data plus a per-lane drive indication, and a low indication stands for the high-impedance state. The path clocks and latch enables are sampled by the block's own system clock, so the whole datapath sits in one synchronous clock domain.

Top module: `ubt_core`

## Requirements
- R1: Lane k (bits 8k+7..8k) is controlled only by the index-k bits of the latch enables, path clocks and output enables. Activity on the other lane's controls or data never changes lane k's outputs.
- R2: While a path's latch enable is 1, the path's data output equals its data input in the same cycle. A-to-B: b_out follows a_in. B-to-A: a_out follows b_in.
- R3: While latch enable is 0 and the sampled path clock shows no 0-to-1 change, the stored value is kept. This covers a clock held low, a clock held high and a clock falling from high to low. The output shows the stored value.
- R4: The path clock is sampled on every rising edge of clk. When latch enable is 0, the path clock is sampled 1, and it was sampled 0 at the edge before, the data input present at that edge is stored. From the next cycle the stored value appears on the output.
- R5: b_drive[k] is 1 exactly when oe_ab_n[k] is 0 (active-low A-to-B enable).
- R6: a_drive[k] is 1 exactly when oe_ba[k] is 1 (active-high B-to-A enable).
- R7: The drive indications depend only on the output enables. The latch enable, path clock and data inputs have no effect on them.
- R8: When a latch enable falls from 1 to 0, the stored value is the last input seen while it was 1. The output keeps that value.
- R9: A synchronous active-high rst clears every stored value to 0. It also records every path clock as already high, so a clock that is high when reset ends causes no capture.
- R10: The block allows both directions of a lane to be enabled at once (oe_ab_n[k]=0 with oe_ba[k]=1). Both drive indications of that lane are then 1, and the block signals this bus-contention case only through those two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples path clocks and updates stores |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | A-side data seen by the A-to-B path |
| b_in | input | 16 | B-side data seen by the B-to-A path |
| le_ab | input | 2 | Per-lane latch enable, A-to-B |
| le_ba | input | 2 | Per-lane latch enable, B-to-A |
| ck_ab | input | 2 | Per-lane path clock level, A-to-B |
| ck_ba | input | 2 | Per-lane path clock level, B-to-A |
| oe_ab_n | input | 2 | Per-lane A-to-B output enable, active low |
| oe_ba | input | 2 | Per-lane B-to-A output enable, active high |
| b_out | output | 16 | B-side data driven by the A-to-B path |
| b_drive | output | 2 | Per-lane B-side drive indication (0 means high impedance) |
| a_out | output | 16 | A-side data driven by the B-to-A path |
| a_drive | output | 2 | Per-lane A-side drive indication (0 means high impedance) |

## Verification
The properties assume that every control and data input is stable around each rising edge of clk. They also assume that a path clock is a level that stays constant for at least one clk period, so the block can see each of its edges as a change between two samples. The bench changes all inputs only on the falling edge of clk and changes each path clock level at most once per clk period. This keeps every stimulus pattern, including the pseudo-random sweep, inside those assumptions. Property checks that look at earlier cycles wait until one cycle after reset has ended, so the bench's reset phase cannot feed them values from before the stores were cleared.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int unsigned UBT_LANES  = 2;
    localparam int unsigned UBT_LANE_W = 8;

    // Controls of one path, with the enable already in active-high form
    typedef struct packed {
        logic le;
        logic ck;
        logic en;
    } ubt_path_ctl_t;

    typedef enum logic [1:0] {
        UBT_HOLD    = 2'd0,
        UBT_FOLLOW  = 2'd1,
        UBT_CAPTURE = 2'd2
    } ubt_mode_e;

    // Store behaviour from the latch enable and two path clock samples
    function automatic ubt_mode_e ubt_pick_mode(input logic le,
                                                input logic ck_now,
                                                input logic ck_prev);
        if (le)
            return UBT_FOLLOW;
        else if (ck_now && !ck_prev)
            return UBT_CAPTURE;
        else
            return UBT_HOLD;
    endfunction

endpackage

// File: rtl/ubt_path.sv
module ubt_path
    import ubt_pkg::*;
#(
    parameter int unsigned W = UBT_LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  d,
    input  ubt_path_ctl_t ctl,
    output logic [W-1:0]  q,
    output logic          drive
);

    logic [W-1:0] store;
    logic         ck_seen;
    ubt_mode_e    mode;

    assign mode = ubt_pick_mode(ctl.le, ctl.ck, ck_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            store   <= '0;
            ck_seen <= 1'b1;
        end else begin
            ck_seen <= ctl.ck;
            case (mode)
                UBT_FOLLOW, UBT_CAPTURE: store <= d;
                default:                 store <= store;
            endcase
        end
    end

    always_comb begin
        q     = (mode == UBT_FOLLOW) ? d : store;
        drive = ctl.en;
    end

endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
    import ubt_pkg::*;
#(
    parameter int unsigned W = UBT_LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  a_side,
    input  logic [W-1:0]  b_side,
    input  ubt_path_ctl_t ctl_ab,
    input  ubt_path_ctl_t ctl_ba,
    output logic [W-1:0]  to_b,
    output logic          to_b_drive,
    output logic [W-1:0]  to_a,
    output logic          to_a_drive
);

    ubt_path #(.W(W)) u_ab (
        .clk   (clk),
        .rst   (rst),
        .d     (a_side),
        .ctl   (ctl_ab),
        .q     (to_b),
        .drive (to_b_drive)
    );

    ubt_path #(.W(W)) u_ba (
        .clk   (clk),
        .rst   (rst),
        .d     (b_side),
        .ctl   (ctl_ba),
        .q     (to_a),
        .drive (to_a_drive)
    );

endmodule

// File: rtl/ubt_core.sv
module ubt_core
    import ubt_pkg::*;
#(
    parameter int unsigned NUM_LANES = UBT_LANES,
    parameter int unsigned LANE_W    = UBT_LANE_W,
    localparam int unsigned BUS_W    = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BUS_W-1:0]     a_in,
    input  logic [BUS_W-1:0]     b_in,
    input  logic [NUM_LANES-1:0] le_ab,
    input  logic [NUM_LANES-1:0] le_ba,
    input  logic [NUM_LANES-1:0] ck_ab,
    input  logic [NUM_LANES-1:0] ck_ba,
    input  logic [NUM_LANES-1:0] oe_ab_n,
    input  logic [NUM_LANES-1:0] oe_ba,
    output logic [BUS_W-1:0]     b_out,
    output logic [NUM_LANES-1:0] b_drive,
    output logic [BUS_W-1:0]     a_out,
    output logic [NUM_LANES-1:0] a_drive
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int unsigned LO = g * LANE_W;
        ubt_path_ctl_t ab_ctl;
        ubt_path_ctl_t ba_ctl;

        // Opposite enable polarities normalised to active high here
        assign ab_ctl = '{le: le_ab[g], ck: ck_ab[g], en: ~oe_ab_n[g]};
        assign ba_ctl = '{le: le_ba[g], ck: ck_ba[g], en: oe_ba[g]};

        ubt_lane #(.W(LANE_W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .a_side     (a_in[LO +: LANE_W]),
            .b_side     (b_in[LO +: LANE_W]),
            .ctl_ab     (ab_ctl),
            .ctl_ba     (ba_ctl),
            .to_b       (b_out[LO +: LANE_W]),
            .to_b_drive (b_drive[g]),
            .to_a       (a_out[LO +: LANE_W]),
            .to_a_drive (a_drive[g])
        );
    end

endmodule

// File: rtl/ubt_core_chk.sv
module ubt_core_chk #(
    parameter int unsigned NUM_LANES = 2,
    parameter int unsigned LANE_W    = 8,
    localparam int unsigned BUS_W    = NUM_LANES * LANE_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic [BUS_W-1:0]     a_in,
    input logic [BUS_W-1:0]     b_in,
    input logic [NUM_LANES-1:0] le_ab,
    input logic [NUM_LANES-1:0] le_ba,
    input logic [NUM_LANES-1:0] ck_ab,
    input logic [NUM_LANES-1:0] ck_ba,
    input logic [NUM_LANES-1:0] oe_ab_n,
    input logic [NUM_LANES-1:0] oe_ba,
    input logic [BUS_W-1:0]     b_out,
    input logic [NUM_LANES-1:0] b_drive,
    input logic [BUS_W-1:0]     a_out,
    input logic [NUM_LANES-1:0] a_drive
);

    logic                 armed;
    logic [NUM_LANES-1:0] ckp_ab;
    logic [NUM_LANES-1:0] ckp_ba;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            ckp_ab <= '1;
            ckp_ba <= '1;
        end else begin
            armed  <= 1'b1;
            ckp_ab <= ck_ab;
            ckp_ba <= ck_ba;
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
        localparam int unsigned LO = g * LANE_W;

        p_follow_ab_r2: assert property (@(posedge clk) disable iff (rst)
            le_ab[g] |-> b_out[LO +: LANE_W] == a_in[LO +: LANE_W]);
        p_follow_ba_r2: assert property (@(posedge clk) disable iff (rst)
            le_ba[g] |-> a_out[LO +: LANE_W] == b_in[LO +: LANE_W]);

        p_keep_ab_r3: assert property (@(posedge clk) disable iff (rst)
            (armed && !le_ab[g] && !(ck_ab[g] && !ckp_ab[g]))
            |=> (le_ab[g] || b_out[LO +: LANE_W] == $past(b_out[LO +: LANE_W])));
        p_keep_ba_r3: assert property (@(posedge clk) disable iff (rst)
            (armed && !le_ba[g] && !(ck_ba[g] && !ckp_ba[g]))
            |=> (le_ba[g] || a_out[LO +: LANE_W] == $past(a_out[LO +: LANE_W])));

        p_edge_ab_r4: assert property (@(posedge clk) disable iff (rst)
            (armed && !le_ab[g] && ck_ab[g] && !ckp_ab[g])
            |=> (le_ab[g] || b_out[LO +: LANE_W] == $past(a_in[LO +: LANE_W])));
        p_edge_ba_r4: assert property (@(posedge clk) disable iff (rst)
            (armed && !le_ba[g] && ck_ba[g] && !ckp_ba[g])
            |=> (le_ba[g] || a_out[LO +: LANE_W] == $past(b_in[LO +: LANE_W])));

        p_bdrive_r5: assert property (@(posedge clk) disable iff (rst)
            b_drive[g] == !oe_ab_n[g]);
        p_adrive_r6: assert property (@(posedge clk) disable iff (rst)
            a_drive[g] == oe_ba[g]);

        p_fall_ab_r8: assert property (@(posedge clk) disable iff (rst)
            (armed && $fell(le_ab[g])) |-> b_out[LO +: LANE_W] == $past(a_in[LO +: LANE_W]));
        p_fall_ba_r8: assert property (@(posedge clk) disable iff (rst)
            (armed && $fell(le_ba[g])) |-> a_out[LO +: LANE_W] == $past(b_in[LO +: LANE_W]));

        p_both_r10: assert property (@(posedge clk) disable iff (rst)
            (!oe_ab_n[g] && oe_ba[g]) |-> (a_drive[g] && b_drive[g]));
    end

endmodule

bind ubt_core ubt_core_chk #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b_in    (b_in),
    .le_ab   (le_ab),
    .le_ba   (le_ba),
    .ck_ab   (ck_ab),
    .ck_ba   (ck_ba),
    .oe_ab_n (oe_ab_n),
    .oe_ba   (oe_ba),
    .b_out   (b_out),
    .b_drive (b_drive),
    .a_out   (a_out),
    .a_drive (a_drive)
);

// File: tb/ubt_core_bench.sv
module ubt_core_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NL = 2;
    localparam int W  = 8;
    localparam int BW = NL * W;

    logic          clk = 1'b0;
    logic          rst;
    logic [BW-1:0] a_in, b_in;
    logic [NL-1:0] le_ab, le_ba, ck_ab, ck_ba, oe_ab_n, oe_ba;
    logic [BW-1:0] b_out, a_out;
    logic [NL-1:0] b_drive, a_drive;

    int n_chk  = 0;
    int n_fail = 0;
    int n_cont = 0;

    logic [W-1:0] ms_ab [NL];
    logic [W-1:0] ms_ba [NL];
    logic         pk_ab [NL];
    logic         pk_ba [NL];
    logic         cap_ab[NL];
    logic         cap_ba[NL];
    logic [31:0]  lfsr = 32'hC0DE_1234;

    always #4 clk = ~clk;

    ubt_core u_ubt_core (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .le_ab(le_ab), .le_ba(le_ba), .ck_ab(ck_ab), .ck_ba(ck_ba),
        .oe_ab_n(oe_ab_n), .oe_ba(oe_ba),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clk period: model update at the rising edge, then sample at the falling edge
    task automatic tick();
        @(posedge clk);
        for (int k = 0; k < NL; k++) begin
            cap_ab[k] = 1'b0;
            cap_ba[k] = 1'b0;
            if (rst) begin
                ms_ab[k] = '0; ms_ba[k] = '0; pk_ab[k] = 1'b1; pk_ba[k] = 1'b1;
            end else begin
                if (le_ab[k]) ms_ab[k] = a_in[k*W +: W];
                else if (ck_ab[k] && !pk_ab[k]) begin
                    ms_ab[k] = a_in[k*W +: W]; cap_ab[k] = 1'b1;
                end
                if (le_ba[k]) ms_ba[k] = b_in[k*W +: W];
                else if (ck_ba[k] && !pk_ba[k]) begin
                    ms_ba[k] = b_in[k*W +: W]; cap_ba[k] = 1'b1;
                end
                pk_ab[k] = ck_ab[k];
                pk_ba[k] = ck_ba[k];
            end
        end
        @(negedge clk);
    endtask

    task automatic compare(input string ctx);
        for (int k = 0; k < NL; k++) begin
            string t_ab, t_ba;
            logic [W-1:0] e_b, e_a;
            t_ab = le_ab[k] ? "R2" : (cap_ab[k] ? "R4" : "R3");
            t_ba = le_ba[k] ? "R2" : (cap_ba[k] ? "R4" : "R3");
            if (ctx != "") begin t_ab = ctx; t_ba = ctx; end
            e_b = le_ab[k] ? a_in[k*W +: W] : ms_ab[k];
            e_a = le_ba[k] ? b_in[k*W +: W] : ms_ba[k];
            chk(t_ab, b_out[k*W +: W], e_b, $sformatf("b_out lane %0d", k));
            chk(t_ba, a_out[k*W +: W], e_a, $sformatf("a_out lane %0d", k));
            chk(ctx != "" ? ctx : "R5", {7'd0, b_drive[k]}, {7'd0, ~oe_ab_n[k]},
                $sformatf("b_drive lane %0d", k));
            chk(ctx != "" ? ctx : "R6", {7'd0, a_drive[k]}, {7'd0, oe_ba[k]},
                $sformatf("a_drive lane %0d", k));
            if (!oe_ab_n[k] && oe_ba[k]) begin
                n_cont++;
                chk("R10", {6'd0, a_drive[k], b_drive[k]}, 8'd3,
                    $sformatf("contention lane %0d", k));
            end
        end
    endtask

    task automatic set_ctl(input logic [NL-1:0] le, input logic [NL-1:0] ck);
        le_ab = le; le_ba = le; ck_ab = ck; ck_ba = ck;
    endtask

    function automatic logic [31:0] step_lfsr(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_in = 16'hFFFF; b_in = 16'hEEEE;
        set_ctl(2'b00, 2'b11);
        oe_ab_n = 2'b00; oe_ba = 2'b00;
        tick(); tick();
        compare("R9");                       // cleared stores under reset
        rst = 1'b0;
        tick(); compare("R9");               // clock held high: no capture at exit
        tick(); compare("R9");

        set_ctl(2'b11, 2'b00);               // transparent
        a_in = 16'hA55A; b_in = 16'h3CC3;
        tick(); compare("R2");
        a_in = 16'h0F0F; b_in = 16'hF00F;
        tick(); compare("R2");

        le_ab = 2'b00; le_ba = 2'b00;        // latch enable falls
        a_in = 16'h1234; b_in = 16'h5678;
        tick(); compare("R8");
        tick(); compare("R3");               // clock static low

        ck_ab = 2'b11; ck_ba = 2'b11;        // rising edge
        a_in = 16'h9ABC; b_in = 16'hDEF0;
        tick(); compare("R4");
        a_in = 16'h1111; b_in = 16'h2222;
        tick(); compare("R3");               // clock static high
        ck_ab = 2'b00; ck_ba = 2'b00;        // falling edge: no capture
        a_in = 16'h3333; b_in = 16'h4444;
        tick(); compare("R3");

        // lane 1 busy, lane 0 held
        for (int i = 0; i < 6; i++) begin
            le_ab = {i[0], 1'b0}; le_ba = {i[1], 1'b0};
            ck_ab = {~ck_ab[1], 1'b0}; ck_ba = {~ck_ba[1], 1'b0};
            a_in = {8'(i * 37), 8'hC7}; b_in = {8'(i * 91), 8'h7C};
            tick(); compare("R1");
        end

        // enables under all patterns of the other controls
        for (int i = 0; i < 64; i++) begin
            oe_ab_n = i[1:0]; oe_ba = i[3:2];
            set_ctl({i[4], i[5]}, {i[5], i[4]});
            a_in = 16'(i * 1103); b_in = 16'(i * 2207);
            tick(); compare("R7");
        end

        oe_ab_n = 2'b00; oe_ba = 2'b11;      // both directions of both lanes
        tick(); compare("R10");

        for (int i = 0; i < 4000; i++) begin
            lfsr = step_lfsr(lfsr);
            a_in = lfsr[15:0];
            lfsr = step_lfsr(lfsr);
            b_in = lfsr[15:0];
            le_ab = lfsr[17:16] & lfsr[19:18];
            le_ba = lfsr[21:20] & lfsr[23:22];
            ck_ab = ck_ab ^ lfsr[25:24];
            ck_ba = ck_ba ^ lfsr[27:26];
            oe_ab_n = lfsr[29:28]; oe_ba = lfsr[31:30];
            tick(); compare("");
        end

        $display("contention cycles seen: %0d", n_cont);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule